// File: doc/BRIEF.md
# IMU Power-Up Configuration Sequencer

This block takes a six-axis inertial sensor from power-on to a fixed working setup. Nothing else has to take part. A single-cycle `start` pulse launches the run. The block first issues a soft reset and then polls until the sensor reports that the reset has finished. It next resets the internal measurement paths and wakes the device on its gyro-referenced clock. When the sensor is wired over SPI, it also switches off the sensor's I2C port. Last, it programs the power, filter, range and interrupt registers. Every register access leaves through a command port with a valid/ready handshake (direction, register address, byte count, write byte) and completes when a one-cycle response arrives. A separate transaction engine drives the serial bus and returns those responses.

All waits are counted in system clock cycles and set by parameters. The defaults suit a 100 MHz clock: about 50 ms between reset polls and about 2 ms after the path reset and after the clock selection. The bench uses much shorter values. When the run completes, `ready` rises and stays high until the next accepted start. If the reset bit is still set after a set number of polls, `error` rises and the block issues no further commands.

Top module: `imu_bringup_seq`

## Requirements
- R1: After reset, `ready`, `error`, `busy` and `cmd_valid` are low, and no command is issued until `start` is seen high at a clock edge.
- R2: The first command of a run is a write (`cmd_write`=1) of 0x80 to register 0x6B. Every command carries `cmd_len`=1. Address, data and direction stay stable while `cmd_valid` is high and `cmd_ready` is low.
- R3: After the response to the reset write, the block waits RESET_WAIT_CYC cycles and then reads register 0x6B (`cmd_write`=0, `cmd_wdata`=0). It repeats this wait and read while bit 7 of the returned byte is 1. Each such read asserts `cmd_valid` exactly RESET_WAIT_CYC+1 cycles after the response cycle that precedes it.
- R4: If the byte from the MAX_POLLS-th read still has bit 7 set, `error` rises on the next cycle and `busy` falls. `error` then stays high, with no further command, until the next start.
- R5: Once the poll sees bit 7 clear, the next command writes 0x07 to register 0x68, one cycle after that response. The command after it waits PATH_WAIT_CYC cycles, so it appears PATH_WAIT_CYC+1 cycles after the path-reset response.
- R6: The block then writes 0x03 to register 0x6B. The following command appears CLK_WAIT_CYC+1 cycles after that response.
- R7: `spi_link` is sampled only in the cycle a start is accepted. If it was 1, the next command writes 0x10 to register 0x6A. If it was 0, that write is left out and the sequence goes straight to the writes of R8.
- R8: The block ends with five writes, in this order: 0x00 to 0x6C, 0x01 to 0x1A, 0x10 to 0x1B, 0x10 to 0x1C and 0x10 to 0x37. Range code 2 sits in bits [4:3] of 0x1B (±1000 deg/s) and of 0x1C (±8 g). Each write follows the previous response by one cycle.
- R9: `ready` goes high the cycle after the response to the last write and stays high until the next accepted start. It is low throughout a run and is never high together with `error`.
- R10: A start pulse that arrives while a run is in progress is ignored. The command stream continues unchanged, and the `spi_link` value present at that time has no effect.
- R11: Each command is issued only after the response to the previous one has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up run (ignored while busy) |
| spi_link | input | 1 | Sensor is wired over SPI; sampled at start |
| cmd_valid | output | 1 | Command offered to the transaction engine |
| cmd_ready | input | 1 | Engine accepts the command this cycle |
| cmd_write | output | 1 | 1 = register write, 0 = register read |
| cmd_addr | output | ADDR_W | Sensor register address |
| cmd_len | output | LEN_W | Number of bytes, always 1 |
| cmd_wdata | output | DATA_W | Byte to write (0 for reads) |
| rsp_valid | input | 1 | One-cycle completion of the accepted command |
| rsp_rdata | input | DATA_W | Byte returned by a read |
| busy | output | 1 | A run is in progress |
| ready | output | 1 | Configuration complete |
| error | output | 1 | Reset poll limit exhausted |

## Verification
The assertions assume the following of the transaction engine. It raises `rsp_valid` for exactly one cycle per accepted command, and only after the command has been accepted. It never raises `cmd_ready` when no command is offered, and `rsp_rdata` carries meaning only in the response cycle. The bench engine keeps to this contract. It accepts a command only while `cmd_valid` is high and pulses a single response after a configurable latency. It changes its inputs only on falling clock edges. It counts reset-register reads so that it can report the reset bit as set for a chosen number of polls, or for all of them.

// File: rtl/imu_seq_pkg.sv
package imu_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RESP,
        ST_HOLD,
        ST_POLL_WAIT,
        ST_POLL_ISSUE,
        ST_POLL_RESP,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        HOLD_NONE,
        HOLD_PATH,
        HOLD_CLK
    } hold_e;

    localparam int STEP_W = 4;

    // Step indices whose position drives the control flow
    localparam logic [STEP_W-1:0] STEP_SOFT_RESET = 4'd0;
    localparam logic [STEP_W-1:0] STEP_PATH_RESET = 4'd1;
    localparam logic [STEP_W-1:0] STEP_PORT_OFF   = 4'd3;
    localparam logic [STEP_W-1:0] STEP_LAST       = 4'd8;

    // Register polled for the self-clearing reset flag, and that flag
    localparam logic [7:0] PWR_CTRL_REG  = 8'h6B;
    localparam logic [7:0] RESET_FLAG    = 8'h80;

    typedef struct packed {
        logic [7:0] reg_addr;
        logic [7:0] value;
        hold_e      hold;
    } step_t;

    typedef struct packed {
        seq_state_e          state;
        logic [STEP_W-1:0]   step;
        logic                spi;
        logic                ready;
        logic                error;
    } seq_regs_t;

    // Fixed bring-up program, one register write per step
    function automatic step_t step_lookup(input logic [STEP_W-1:0] idx);
        step_t s;
        unique case (idx)
            4'd0:    s = '{reg_addr: 8'h6B, value: 8'h80, hold: HOLD_NONE};
            4'd1:    s = '{reg_addr: 8'h68, value: 8'h07, hold: HOLD_PATH};
            4'd2:    s = '{reg_addr: 8'h6B, value: 8'h03, hold: HOLD_CLK};
            4'd3:    s = '{reg_addr: 8'h6A, value: 8'h10, hold: HOLD_NONE};
            4'd4:    s = '{reg_addr: 8'h6C, value: 8'h00, hold: HOLD_NONE};
            4'd5:    s = '{reg_addr: 8'h1A, value: 8'h01, hold: HOLD_NONE};
            4'd6:    s = '{reg_addr: 8'h1B, value: 8'h10, hold: HOLD_NONE};
            4'd7:    s = '{reg_addr: 8'h1C, value: 8'h10, hold: HOLD_NONE};
            4'd8:    s = '{reg_addr: 8'h37, value: 8'h10, hold: HOLD_NONE};
            default: s = '{reg_addr: 8'h00, value: 8'h00, hold: HOLD_NONE};
        endcase
        return s;
    endfunction

    // Steps that only apply to a serial-peripheral link
    function automatic logic step_spi_only(input logic [STEP_W-1:0] idx);
        return idx == STEP_PORT_OFF;
    endfunction

endpackage

// File: rtl/imu_seq_timer.sv
module imu_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // R3
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/imu_seq_poll.sv
module imu_seq_poll #(
    parameter int MAX_POLLS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);

    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (bump) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == PW'(MAX_POLLS - 1));

    // R4
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < PW'(MAX_POLLS));

endmodule

// File: rtl/imu_seq_rom.sv
module imu_seq_rom
    import imu_seq_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    input  logic              spi,
    output logic [7:0]        reg_addr,
    output logic [7:0]        value,
    output hold_e             hold,
    output logic [STEP_W-1:0] next_idx
);

    step_t             ent;
    logic [STEP_W-1:0] inc;

    always_comb begin
        ent      = step_lookup(idx);
        reg_addr = ent.reg_addr;
        value    = ent.value;
        hold     = ent.hold;
        inc      = idx + 1'b1;
        next_idx = (step_spi_only(inc) && !spi) ? inc + 1'b1 : inc;
    end

endmodule

// File: rtl/imu_bringup_seq.sv
module imu_bringup_seq
    import imu_seq_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 8,
    parameter int LEN_W          = 4,
    parameter int RESET_WAIT_CYC = 5_000_000,
    parameter int PATH_WAIT_CYC  = 200_000,
    parameter int CLK_WAIT_CYC   = 200_000,
    parameter int MAX_POLLS      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              spi_link,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              ready,
    output logic              error
);

    localparam int LONG_A  = (RESET_WAIT_CYC > PATH_WAIT_CYC) ? RESET_WAIT_CYC : PATH_WAIT_CYC;
    localparam int LONGEST = (LONG_A > CLK_WAIT_CYC) ? LONG_A : CLK_WAIT_CYC;
    localparam int TMR_W   = $clog2(LONGEST + 1);
    localparam logic [TMR_W-1:0] RESET_LOAD = TMR_W'(RESET_WAIT_CYC - 1);
    localparam logic [TMR_W-1:0] PATH_LOAD  = TMR_W'(PATH_WAIT_CYC - 1);
    localparam logic [TMR_W-1:0] CLK_LOAD   = TMR_W'(CLK_WAIT_CYC - 1);
    localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(RESET_FLAG);

    seq_regs_t         seq_d, seq_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              poll_clr;
    logic              poll_bump;
    logic              poll_last;
    logic              advance;
    logic              flag_clear;
    logic [7:0]        step_addr;
    logic [7:0]        step_value;
    hold_e             step_hold;
    logic [STEP_W-1:0] step_next;

    imu_seq_rom u_rom (
        .idx      (seq_q.step),
        .spi      (seq_q.spi),
        .reg_addr (step_addr),
        .value    (step_value),
        .hold     (step_hold),
        .next_idx (step_next)
    );

    imu_seq_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    imu_seq_poll #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clr),
        .bump  (poll_bump),
        .last  (poll_last)
    );

    assign flag_clear = ((rsp_rdata & FLAG_MASK) == '0);

    always_comb begin
        seq_d     = seq_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        poll_clr  = 1'b0;
        poll_bump = 1'b0;
        advance   = 1'b0;

        unique case (seq_q.state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    seq_d.state = ST_ISSUE;
                    seq_d.step  = STEP_SOFT_RESET;
                    seq_d.spi   = spi_link;
                    seq_d.ready = 1'b0;
                    seq_d.error = 1'b0;
                    poll_clr    = 1'b1;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    seq_d.state = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_valid) begin
                    if (seq_q.step == STEP_SOFT_RESET) begin
                        tmr_load    = 1'b1;
                        tmr_val     = RESET_LOAD;
                        seq_d.state = ST_POLL_WAIT;
                    end else if (step_hold == HOLD_PATH) begin
                        tmr_load    = 1'b1;
                        tmr_val     = PATH_LOAD;
                        seq_d.state = ST_HOLD;
                    end else if (step_hold == HOLD_CLK) begin
                        tmr_load    = 1'b1;
                        tmr_val     = CLK_LOAD;
                        seq_d.state = ST_HOLD;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    advance = 1'b1;
                end
            end
            ST_POLL_WAIT: begin
                if (tmr_expired) begin
                    seq_d.state = ST_POLL_ISSUE;
                end
            end
            ST_POLL_ISSUE: begin
                if (cmd_ready) begin
                    seq_d.state = ST_POLL_RESP;
                end
            end
            ST_POLL_RESP: begin
                if (rsp_valid) begin
                    if (flag_clear) begin
                        seq_d.step  = STEP_PATH_RESET;
                        seq_d.state = ST_ISSUE;
                    end else if (poll_last) begin
                        seq_d.state = ST_FAIL;
                        seq_d.error = 1'b1;
                    end else begin
                        poll_bump   = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = RESET_LOAD;
                        seq_d.state = ST_POLL_WAIT;
                    end
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase

        if (advance) begin
            if (seq_q.step == STEP_LAST) begin
                seq_d.state = ST_DONE;
                seq_d.ready = 1'b1;
            end else begin
                seq_d.step  = step_next;
                seq_d.state = ST_ISSUE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, step: '0, spi: 1'b0, ready: 1'b0, error: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_valid = (seq_q.state == ST_ISSUE) || (seq_q.state == ST_POLL_ISSUE);
    assign cmd_write = (seq_q.state == ST_ISSUE);
    assign cmd_addr  = (seq_q.state == ST_POLL_ISSUE) ? ADDR_W'(PWR_CTRL_REG) : ADDR_W'(step_addr);
    assign cmd_wdata = (seq_q.state == ST_ISSUE) ? DATA_W'(step_value) : '0;
    assign cmd_len   = LEN_W'(1);
    assign busy      = !((seq_q.state == ST_IDLE) || (seq_q.state == ST_DONE) ||
                         (seq_q.state == ST_FAIL));
    assign ready     = seq_q.ready;
    assign error     = seq_q.error;

    // R2
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                       $stable(cmd_wdata) && $stable(cmd_write)));

    // R9
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!error && !cmd_valid && !busy));

    // R4
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> ($past(rsp_valid) && $past(rsp_rdata[7])));

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !ready && !error));

    // R11
    no_issue_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_valid && !rsp_valid && !tmr_expired) |=> !cmd_valid);

endmodule

// File: tb/imu_bringup_seq_tb_top.sv
module imu_bringup_seq_tb_top;

    localparam int RW = 20;
    localparam int PW = 7;
    localparam int CW = 5;
    localparam int MP = 4;

    typedef struct {
        bit         wr;
        logic [7:0] addr;
        logic [7:0] data;
        int         gap;
        string      tag;
    } txn_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       spi_link = 1'b0;
    logic       cmd_valid;
    logic       cmd_ready = 1'b0;
    logic       cmd_write;
    logic [7:0] cmd_addr;
    logic [3:0] cmd_len;
    logic [7:0] cmd_wdata;
    logic       rsp_valid = 1'b0;
    logic [7:0] rsp_rdata = 8'h00;
    logic       busy;
    logic       ready;
    logic       error;

    int   n_chk = 0;
    int   n_err = 0;
    txn_t exp_q[$];
    int   ready_dly = 0;
    int   rsp_lat = 1;
    int   set_reads = 0;
    int   reads_seen = 0;
    bit   arm_start = 0;
    bit   run_active = 0;
    bit   fail_mode = 0;
    bit   ready_exp = 0;
    bit   err_exp = 0;
    bit   armed = 0;
    int   gap = 0;

    always #2 clk = ~clk;

    imu_bringup_seq #(
        .ADDR_W(8), .DATA_W(8), .LEN_W(4),
        .RESET_WAIT_CYC(RW), .PATH_WAIT_CYC(PW), .CLK_WAIT_CYC(CW), .MAX_POLLS(MP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .spi_link(spi_link),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .busy(busy), .ready(ready), .error(error)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Transaction engine model
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_valid && rst_n) begin
                bit         w;
                logic [7:0] a;
                repeat (ready_dly) @(negedge clk);
                w = cmd_write;
                a = cmd_addr;
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                repeat (rsp_lat) @(negedge clk);
                rsp_rdata = 8'h00;
                if (!w && a == 8'h6B) begin
                    rsp_rdata = (reads_seen < set_reads) ? 8'h80 : 8'h00;
                    reads_seen++;
                end
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_rdata = 8'h00;
            end
        end
    end

    // Reference model, compared every cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                chk(ready === ready_exp, "R9", "ready", int'(ready), int'(ready_exp));
                chk(error === err_exp, "R4", "error", int'(error), int'(err_exp));
                if (armed) gap++;
                if (cmd_valid && armed) begin
                    if (exp_q.size() > 0)
                        chk(gap == exp_q[0].gap, exp_q[0].tag, "issue gap", gap, exp_q[0].gap);
                    armed = 0;
                end
                if (cmd_valid && cmd_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R11", "unexpected command addr", int'(cmd_addr), 0);
                    end else begin
                        txn_t t;
                        t = exp_q.pop_front();
                        chk(cmd_write == t.wr, t.tag, "direction", int'(cmd_write), int'(t.wr));
                        chk(cmd_addr == t.addr, t.tag, "address", int'(cmd_addr), int'(t.addr));
                        chk(cmd_wdata == t.data, t.tag, "data", int'(cmd_wdata), int'(t.data));
                        chk(cmd_len == 4'd1, "R2", "length", int'(cmd_len), 1);
                    end
                end
                if (rsp_valid && run_active) begin
                    if (exp_q.size() == 0) begin
                        ready_exp  = !fail_mode;
                        err_exp    = fail_mode;
                        run_active = 0;
                    end else begin
                        armed = 1;
                        gap   = 0;
                    end
                end
                if (start && arm_start) begin
                    arm_start  = 0;
                    armed      = 1;
                    gap        = 0;
                    ready_exp  = 0;
                    err_exp    = 0;
                    run_active = 1;
                end
            end
        end
    end

    task automatic push(input bit w, input logic [7:0] a, input logic [7:0] d,
                        input int g, input string tag);
        txn_t t;
        t.wr = w; t.addr = a; t.data = d; t.gap = g; t.tag = tag;
        exp_q.push_back(t);
    endtask

    task automatic run_seq(input bit spi, input int nset, input bit fail,
                           input int rdly, input int lat, input bit poke);
        int g;
        exp_q.delete();
        push(1, 8'h6B, 8'h80, 1, "R2");
        if (fail) begin
            for (int i = 0; i < MP; i++) push(0, 8'h6B, 8'h00, RW + 1, "R3");
        end else begin
            for (int i = 0; i <= nset; i++) push(0, 8'h6B, 8'h00, RW + 1, "R3");
            push(1, 8'h68, 8'h07, 1, "R5");
            push(1, 8'h6B, 8'h03, PW + 1, "R6");
            g = CW + 1;
            if (spi) begin
                push(1, 8'h6A, 8'h10, g, "R7");
                g = 1;
            end
            push(1, 8'h6C, 8'h00, g, "R8");
            push(1, 8'h1A, 8'h01, 1, "R8");
            push(1, 8'h1B, 8'h10, 1, "R8");
            push(1, 8'h1C, 8'h10, 1, "R8");
            push(1, 8'h37, 8'h10, 1, "R8");
        end
        ready_dly  = rdly;
        rsp_lat    = lat;
        set_reads  = fail ? 1000 : nset;
        reads_seen = 0;
        fail_mode  = fail;
        @(negedge clk);
        arm_start = 1;
        start     = 1'b1;
        spi_link  = spi;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R10: start and a different link choice mid-run
            repeat (15) @(negedge clk);
            start    = 1'b1;
            spi_link = !spi;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 3000 && (run_active || exp_q.size() != 0); i++) @(negedge clk);
        chk(exp_q.size() == 0, fail ? "R4" : "R8", "commands outstanding", exp_q.size(), 0);
        repeat (30) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R9", "busy after run", int'(busy), 0);
        chk(ready == !fail, "R9", "ready held", int'(ready), int'(!fail));
        chk(error == fail, "R4", "error held", int'(error), int'(fail));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        #1;
        // R1: idle after reset with no start
        chk(cmd_valid == 1'b0, "R1", "cmd_valid idle", int'(cmd_valid), 0);
        chk(busy == 1'b0, "R1", "busy idle", int'(busy), 0);
        chk(ready == 1'b0, "R1", "ready idle", int'(ready), 0);
        chk(error == 1'b0, "R1", "error idle", int'(error), 0);
        // SPI link, reset flag set on two polls, ignored start mid-run (R10)
        run_seq(1, 2, 0, 0, 1, 1);
        // I2C link, flag clear on first poll, slow engine (R7)
        run_seq(0, 0, 0, 3, 4, 0);
        // Reset flag never clears (R4)
        run_seq(1, 0, 1, 1, 2, 0);
        // Restart after failure clears error (R9)
        run_seq(1, 1, 0, 2, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule